// File: doc/BRIEF.md
# Three-Phase Sine DAC Sequencer

This block produces three sine waves spaced a third of a period apart by repeatedly loading a quad voltage-output DAC over its shared parallel bus. One base index points into a 256-entry, 8-bit sine table. The table is computed when the design is elaborated. For every table step the block writes a triad of samples: one to channel A at the base index, one to channel B a third of the table further on, and one to channel C two thirds further on. After the triad, the base index moves on by one. Stepping through all 256 indices gives one full output period, so each period step is 360/256 degrees.

Each write drives the channel address and the data byte onto the bus, pulls the active-low write strobe low, releases it, and then holds address and data for a while. The setup, strobe-low and hold times are parameters counted in clock cycles. A step divider input inserts a number of idle cycles between triads, and this sets the output frequency. The enable input starts and pauses the sequence. A pause never cuts a triad short, and the base index is kept so that the next run continues where the last one stopped. The fourth converter channel is left alone, so it can produce the reference voltage.

Top module: `tri_sine_seq`

## Requirements
- R1: While reset is asserted and right after it, the strobe is high, the address is 0 and the data is 0x80, and the base index is 0.
- R2: Table entry i (0..255) has the value 128+f when i<128 and 128-f otherwise. Here a = i mod 128, p = a*(128-a), and f = floor(2032*p / (81920-4*p)).
- R3: In the triad with base index t, channel A gets entry t, channel B gets entry (t+85) mod 256 and channel C gets entry (t+171) mod 256.
- R4: Writes always come in the order A, B, C, using address codes 0, 1 and 2 for A, B and C. Address code 3 is never driven.
- R5: Each write holds the strobe low for exactly PULSE_CYC consecutive cycles.
- R6: Address and data are driven SETUP_CYC cycles before the strobe falls. They stay unchanged while the strobe is low and for HOLD_CYC cycles after it rises.
- R7: Between triads, exactly step_div idle cycles pass with the strobe high. When step_div is 0, the setup of the next triad starts in the cycle right after the last hold cycle.
- R8: The base index goes up by one after each triad, modulo 256. The 257th triad therefore writes the same samples as the first.
- R9: When enable drops, the current triad still finishes and then no further write happens. When enable returns, the next triad uses the index that follows the last finished triad.
- R10: When the block is idle and sees enable high, the setup of channel A starts on the next cycle. The strobe falls SETUP_CYC+1 cycles after enable is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the sequence when high; pause after the current triad when low |
| step_div | input | DIV_W | Number of idle cycles between triads |
| dac_data | output | DW | Sample byte on the shared DAC bus |
| dac_addr | output | 2 | Channel address (0=A, 1=B, 2=C) |
| dac_wr_n | output | 1 | Active-low write strobe |

## Verification
A bad base index or a bad channel counter shows up on the very next strobe edge. Every write's data is compared with the table entry that the write count predicts, and its address with the expected channel order, so a fault shows within one write of roughly 28 cycles. A bad wait counter changes the strobe width or the idle gap, and the per-cycle comparison catches this on the first cycle the strobe differs. A pause that loses or skips an index shows as wrong data in the first channel A write after resuming.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    localparam logic [1:0] CH_FIRST    = 2'd0;
    localparam logic [1:0] CH_LAST     = 2'd2;
    localparam logic [1:0] CH_RESERVED = 2'd3;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Half-wave rational sine approximation, scaled to an unsigned code.
    function automatic int sine_code(input int idx, input int depth, input int dw);
        longint half;
        longint a;
        longint p;
        longint amp;
        longint mid;
        longint off;
        half = longint'(depth / 2);
        a    = longint'(idx) % half;
        p    = a * (half - a);
        amp  = (longint'(1) << (dw - 1)) - 1;
        mid  = longint'(1) << (dw - 1);
        off  = (amp * 16 * p) / (5 * half * half - 4 * p);
        if (longint'(idx) < half) return int'(mid + off);
        return int'(mid - off);
    endfunction

endpackage

// File: rtl/tsq_sine_rom.sv
module tsq_sine_rom
    import tsq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic [AW-1:0] idx,
    output logic [DW-1:0] sample
);

    localparam int DEPTH = 1 << AW;

    function automatic logic [DEPTH-1:0][DW-1:0] build_table();
        logic [DEPTH-1:0][DW-1:0] t;
        for (int i = 0; i < DEPTH; i++) begin
            t[i] = DW'(sine_code(i, DEPTH, DW));
        end
        return t;
    endfunction

    localparam logic [DEPTH-1:0][DW-1:0] WAVE = build_table();

    assign sample = WAVE[idx];

endmodule

// File: rtl/tsq_phase_sel.sv
module tsq_phase_sel #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    ch,
    output logic [AW-1:0] idx
);

    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] ch_idx [3];

    for (genvar g = 0; g < 3; g++) begin : g_phase
        localparam int OFFSET = (g * DEPTH + 1) / 3;
        assign ch_idx[g] = base + AW'(OFFSET);
    end

    always_comb begin
        case (ch)
            2'd0:    idx = ch_idx[0];
            2'd1:    idx = ch_idx[1];
            2'd2:    idx = ch_idx[2];
            default: idx = base;
        endcase
    end

endmodule

// File: rtl/tri_sine_seq.sv
module tri_sine_seq
    import tsq_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int DIV_W     = 8,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 25,
    parameter int HOLD_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] step_div,
    output logic [DW-1:0]    dac_data,
    output logic [1:0]       dac_addr,
    output logic             dac_wr_n
);

    localparam int LONGEST = max_int(max_int(SETUP_CYC, PULSE_CYC),
                                     max_int(HOLD_CYC, (1 << DIV_W) - 1));
    localparam int CNT_W = $clog2(LONGEST + 1);
    localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        seq_state_e     st;
        logic [1:0]     ch;
        logic [AW-1:0]  base;
        logic [CNT_W-1:0] cnt;
        logic           wr_n;
        logic [1:0]     addr;
        logic [DW-1:0]  data;
    } seq_t;

    seq_t r_q, r_d;

    logic          in_hold;
    logic          last_ch;
    logic [AW-1:0] lk_base;
    logic [AW-1:0] lk_idx;
    logic [1:0]    lk_ch;
    logic [DW-1:0] lk_sample;

    // Lookahead: the index and channel of the write that would start next.
    always_comb begin
        in_hold = (r_q.st == ST_HOLD);
        last_ch = (r_q.ch == CH_LAST);
        lk_base = (in_hold && last_ch) ? r_q.base + AW'(1) : r_q.base;
        lk_ch   = (in_hold && !last_ch) ? r_q.ch + 2'd1 : CH_FIRST;
    end

    tsq_phase_sel #(.AW(AW)) u_phase (
        .base (lk_base),
        .ch   (lk_ch),
        .idx  (lk_idx)
    );

    tsq_sine_rom #(.AW(AW), .DW(DW)) u_rom (
        .idx    (lk_idx),
        .sample (lk_sample)
    );

    always_comb begin
        logic go;
        r_d = r_q;
        go  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                go = enable;
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_PULSE;
                    r_d.wr_n = 1'b0;
                    r_d.cnt  = CNT_W'(PULSE_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_HOLD;
                    r_d.wr_n = 1'b1;
                    r_d.cnt  = CNT_W'(HOLD_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (!last_ch) begin
                    go = 1'b1;
                end else begin
                    r_d.base = r_q.base + AW'(1);
                    if (step_div == '0) begin
                        go = enable;
                        if (!enable) r_d.st = ST_IDLE;
                    end else begin
                        r_d.st  = ST_GAP;
                        r_d.cnt = CNT_W'(step_div) - CNT_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (r_q.cnt == '0) begin
                    go = enable;
                    if (!enable) r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
        if (go) begin
            r_d.st   = ST_SETUP;
            r_d.ch   = lk_ch;
            r_d.addr = lk_ch;
            r_d.data = lk_sample;
            r_d.wr_n = 1'b1;
            r_d.cnt  = CNT_W'(SETUP_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.ch   <= CH_FIRST;
            r_q.base <= '0;
            r_q.cnt  <= '0;
            r_q.wr_n <= 1'b1;
            r_q.addr <= CH_FIRST;
            r_q.data <= MID_CODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_data = r_q.data;
    assign dac_addr = r_q.addr;
    assign dac_wr_n = r_q.wr_n;

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker
    import tsq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PULSE_CYC = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dac_wr_n,
    input logic [1:0]    dac_addr,
    input logic [DW-1:0] dac_data
);

    logic [15:0] low_q;
    logic [1:0]  last_q;
    logic        wr_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q     <= '0;
            last_q    <= CH_LAST;
            wr_prev_q <= 1'b1;
        end else begin
            low_q     <= dac_wr_n ? 16'd0 : low_q + 16'd1;
            wr_prev_q <= dac_wr_n;
            if (wr_prev_q && !dac_wr_n) last_q <= dac_addr;
        end
    end

    // R4: the reserved channel is never addressed
    p_no_chan_d_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_addr != CH_RESERVED);

    // R4: each strobe targets the channel after the previous one
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prev_q && !dac_wr_n) |->
            dac_addr == ((last_q == CH_LAST) ? CH_FIRST : last_q + 2'd1));

    // R5: strobe-low width
    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> low_q == 16'(PULSE_CYC));

    // R6: address and data settled when the strobe falls
    p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

    // R6: nothing moves while the strobe is low or as it rises
    p_steady_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

    // R6: address only changes while the strobe is high
    p_addr_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_addr) |-> (dac_wr_n && $past(dac_wr_n)));

endmodule

bind tri_sine_seq tsq_checker #(.DW(DW), .PULSE_CYC(PULSE_CYC)) u_tsq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_wr_n (dac_wr_n),
    .dac_addr (dac_addr),
    .dac_data (dac_data)
);

// File: tb/tri_sine_seq_bench.sv
module tri_sine_seq_bench;

    localparam int SETUP = 1;
    localparam int PULSE = 25;
    localparam int HOLD  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] step_div = 8'd0;
    logic [7:0] dac_data;
    logic [1:0] dac_addr;
    logic       dac_wr_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tri_sine_seq u_tri_sine_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .step_div (step_div),
        .dac_data (dac_data),
        .dac_addr (dac_addr),
        .dac_wr_n (dac_wr_n)
    );

    function automatic int sine_ref(input int i);
        int a;
        int p;
        int f;
        a = i % 128;
        p = a * (128 - a);
        f = (2032 * p) / (81920 - 4 * p);
        return (i < 128) ? 128 + f : 128 - f;
    endfunction

    function automatic int phase_off(input int c);
        return (c * 256 + 1) / 3;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model: a queue of expected bus values, one entry per cycle.
    typedef struct {
        int wr;
        int addr;
        int data;
    } ent_t;

    ent_t mq[$];
    int m_wr = 1;
    int m_addr = 0;
    int m_data = 128;
    int m_triad = 0;

    task automatic push_triad();
        int d;
        d = 0;
        for (int c = 0; c < 3; c++) begin
            d = sine_ref((m_triad + phase_off(c)) % 256);
            for (int k = 0; k < SETUP; k++) mq.push_back('{1, c, d});
            for (int k = 0; k < PULSE; k++) mq.push_back('{0, c, d});
            for (int k = 0; k < HOLD; k++)  mq.push_back('{1, c, d});
        end
        for (int k = 0; k < int'(step_div); k++) mq.push_back('{1, 2, d});
        m_triad++;
    endtask

    always @(posedge clk) begin
        ent_t e;
        cyc++;
        if (!rst_n) begin
            m_wr = 1; m_addr = 0; m_data = 128; m_triad = 0;
            mq.delete();
        end else begin
            if (mq.size() == 0) begin
                if (enable) push_triad();
                else mq.push_back('{m_wr, m_addr, m_data});
            end
            e = mq.pop_front();
            m_wr = e.wr; m_addr = e.addr; m_data = e.data;
        end
    end

    // Monitor: compare every cycle and log writes
    int nwrites = 0;
    int low_run = 0;
    int chan_d_seen = 0;
    int fall_cyc [0:1023];
    int fall_data [0:1023];
    int cap_addr = 0;
    int cap_data = 0;
    logic prev_wr = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(dac_wr_n) == m_wr, "R5 strobe vs model", int'(dac_wr_n), m_wr);
            check(int'(dac_addr) == m_addr, "R4 address vs model", int'(dac_addr), m_addr);
            check(int'(dac_data) == m_data, "R3 data vs model", int'(dac_data), m_data);
            if (dac_addr == 2'd3) chan_d_seen++;
            if (prev_wr && !dac_wr_n) begin
                int t;
                int c;
                t = nwrites / 3;
                c = nwrites % 3;
                check(int'(dac_addr) == c, "R4 write order", int'(dac_addr), c);
                check(int'(dac_data) == sine_ref((t + phase_off(c)) % 256),
                      "R8 write sample", int'(dac_data), sine_ref((t + phase_off(c)) % 256));
                if (nwrites < 1024) begin
                    fall_cyc[nwrites]  = cyc;
                    fall_data[nwrites] = int'(dac_data);
                end
                cap_addr = int'(dac_addr);
                cap_data = int'(dac_data);
                nwrites++;
                low_run = 0;
            end
            if (!dac_wr_n) low_run++;
            if (!prev_wr && dac_wr_n) begin
                check(low_run == PULSE, "R5 strobe width", low_run, PULSE);
                check(int'(dac_addr) == cap_addr, "R6 address held", int'(dac_addr), cap_addr);
                check(int'(dac_data) == cap_data, "R6 data held", int'(dac_data), cap_data);
            end
            prev_wr = dac_wr_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int en_cyc;
        int base;
        int k;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(dac_wr_n == 1'b1, "R1 reset strobe", int'(dac_wr_n), 1);
        check(dac_addr == 2'd0, "R1 reset address", int'(dac_addr), 0);
        check(dac_data == 8'h80, "R1 reset data", int'(dac_data), 128);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_data == 8'h80 && dac_wr_n, "R1 after release", int'(dac_data), 128);

        // Full period with no gap
        en_cyc = cyc;
        enable = 1'b1;
        wait (nwrites >= 771);
        @(negedge clk);
        check(fall_cyc[0] - en_cyc == SETUP + 1, "R10 start latency",
              fall_cyc[0] - en_cyc, SETUP + 1);
        check(fall_data[0] == 128, "R2 entry 0", fall_data[0], 128);
        check(fall_data[1] == 238, "R2 entry 85", fall_data[1], 238);
        check(fall_data[2] == 18, "R3 channel C sample", fall_data[2], 18);
        check(fall_cyc[3] - fall_cyc[2] == PULSE + HOLD + SETUP, "R7 zero divider",
              fall_cyc[3] - fall_cyc[2], PULSE + HOLD + SETUP);
        check(fall_data[768] == fall_data[0], "R8 wrap after 256 triads",
              fall_data[768], fall_data[0]);

        // Pause
        enable = 1'b0;
        repeat (300) @(negedge clk);
        check(nwrites % 3 == 0, "R9 triad completes", nwrites % 3, 0);
        k = nwrites;
        repeat (100) @(negedge clk);
        check(nwrites == k, "R9 no writes while paused", nwrites, k);

        // Divider of five, then a pause in the middle of a triad
        step_div = 8'd5;
        base = nwrites;
        enable = 1'b1;
        wait (nwrites >= base + 5);
        check(fall_cyc[base + 3] - fall_cyc[base + 2] == PULSE + HOLD + 5 + SETUP,
              "R7 divider gap", fall_cyc[base + 3] - fall_cyc[base + 2],
              PULSE + HOLD + 5 + SETUP);
        enable = 1'b0;
        repeat (300) @(negedge clk);
        check(nwrites % 3 == 0, "R9 mid-triad pause", nwrites % 3, 0);
        check(nwrites == base + 6, "R9 pause write count", nwrites, base + 6);

        // Resume; the monitor checks the next index
        base = nwrites;
        enable = 1'b1;
        wait (nwrites >= base + 3);
        enable = 1'b0;
        repeat (200) @(negedge clk);
        check(nwrites == base + 3, "R9 resume triad", nwrites, base + 3);
        check(chan_d_seen == 0, "R4 reserved channel", chan_d_seen, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule